// File: doc/BRIEF.md
# Synchronous Serial Shift Interface

This block moves one byte at a time over a three-wire synchronous serial link and generates the link's clock itself. The host writes a byte into the shift register and then writes a one to the busy control. The block then drives the serial clock and the serial data output, and it captures the serial data input. After eight bits the busy flag drops, a pending flag rises, and the byte that arrived on the input replaces the shift register contents.

The serial clock runs at a fraction of the block clock. A two-bit select chooses that fraction, and it is captured when each transfer starts. The pending flag raises an interrupt request only while its enable is set. The pending flag stays set until the host clears it. A routing bit decides what drives the two output pins. When the bit is set, the pins carry the serial clock and the serial data. When it is clear, they carry general-purpose values supplied from outside.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, busy and pend are 0, irq is 0, the internal serial clock is low and shreg reads 0x00.
- R2: The serial clock period is 2, 4 or 8 block clock cycles when div_sel is 00, 01 or 1x. From the start edge to the edge where busy clears there are 15 half periods: 15, 30 or 60 cycles.
- R3: Writing busy_wdata=1 with busy_wr while idle starts a transfer, and busy reads 1 throughout it. The same write during a transfer has no effect on its length.
- R4: Bits go out and come in most significant bit first. Serial out takes its first bit at the start and changes only when the serial clock falls. Serial in is sampled when the serial clock rises.
- R5: In the cycle that the eighth bit is sampled, busy clears, pend sets and shreg takes the received byte.
- R6: A write to shreg while busy is 1 is ignored, and the bits sent are those loaded before the start.
- R7: Writing busy_wdata=0 with busy_wr during a transfer ends it at the next edge and leaves pend unchanged.
- R8: irq is 1 exactly when pend and irq_en are both 1. pend_clr clears pend, but a completion in the same cycle takes priority.
- R9: With route_en=1, pin_sck and pin_so carry the serial clock and serial data. With route_en=0 they follow gp_sck and gp_so.
- R10: The serial clock is low in every cycle where busy is 0 and was also 0 in the previous cycle. The eighth high phase therefore lasts one block clock cycle.
- R11: div_sel is captured at the start, and changing it during a transfer does not change that transfer's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 2 | Serial clock divide select |
| route_en | input | 1 | Route serial clock and data to the pins |
| irq_en | input | 1 | Interrupt enable |
| sh_wr | input | 1 | Shift register write strobe |
| sh_wdata | input | 8 | Shift register write data |
| busy_wr | input | 1 | Busy control write strobe |
| busy_wdata | input | 1 | Busy control write value |
| pend_clr | input | 1 | Clear pending flag |
| sin | input | 1 | Serial data input |
| gp_sck | input | 1 | General-purpose value for the clock pin |
| gp_so | input | 1 | General-purpose value for the data pin |
| shreg | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| pend | output | 1 | Transfer complete pending flag |
| irq | output | 1 | Interrupt request |
| pin_sck | output | 1 | Clock pin |
| pin_so | output | 1 | Data pin |

## Verification
The hardest cases to reach are the host writes that land in the middle of a transfer. These are a shift register write, a second start, a divide change and an abort, and each must arrive at a known bit position. The stimulus counts block clock cycles from the start edge and issues the disturbing write on the fifth cycle of busy. A slave model follows the serial clock pins and supplies input bits. The bench then checks the transfer length, the bits captured on the data pin and the pending flag against values from an undisturbed transfer.

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   div_sel,
  input  logic         route_en,
  input  logic         irq_en,
  input  logic         sh_wr,
  input  logic [W-1:0] sh_wdata,
  input  logic         busy_wr,
  input  logic         busy_wdata,
  input  logic         pend_clr,
  input  logic         sin,
  input  logic         gp_sck,
  input  logic         gp_so,
  output logic [W-1:0] shreg,
  output logic         busy,
  output logic         pend,
  output logic         irq,
  output logic         pin_sck,
  output logic         pin_so
);
  localparam int BW = (W > 2) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic [1:0]    half_sel, half_lim, cnt;
  logic [BW-1:0] bitn;
  logic          sck_r, so_r;
  logic          abort_wr, start_wr, tick;

  always_comb begin
    case (div_sel)
      2'b00:   half_sel = 2'd0;
      2'b01:   half_sel = 2'd1;
      default: half_sel = 2'd3;
    endcase
  end

  assign abort_wr = busy_wr && !busy_wdata;
  assign start_wr = busy_wr && busy_wdata;
  assign tick     = (cnt == half_lim);
  assign irq      = pend && irq_en;
  assign pin_sck  = route_en ? sck_r : gp_sck;
  assign pin_so   = route_en ? so_r  : gp_so;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      busy     <= 1'b0;
      pend     <= 1'b0;
      sck_r    <= 1'b0;
      so_r     <= 1'b0;
      cnt      <= '0;
      half_lim <= '0;
      bitn     <= '0;
    end else begin
      if (pend_clr) pend <= 1'b0;
      if (!busy) begin
        sck_r <= 1'b0;
        if (sh_wr) shreg <= sh_wdata;
        if (start_wr) begin
          busy     <= 1'b1;
          cnt      <= '0;
          bitn     <= '0;
          half_lim <= half_sel;
          so_r     <= sh_wr ? sh_wdata[W-1] : shreg[W-1];
        end
      end else if (abort_wr) begin
        busy  <= 1'b0;
        sck_r <= 1'b0;
      end else if (tick) begin
        cnt <= '0;
        if (!sck_r) begin
          sck_r <= 1'b1;
          shreg <= {shreg[W-2:0], sin};
          bitn  <= bitn + 1'b1;
          if (bitn == LAST) begin
            busy <= 1'b0;
            pend <= 1'b1;
          end
        end else begin
          sck_r <= 1'b0;
          so_r  <= shreg[W-1];
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !sck_r);

  // R4
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(sck_r) |-> $stable(so_r));

  // R6
  shreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$rose(sck_r) |-> $stable(shreg));

  // R5
  done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort_wr) |-> pend && sck_r);

  // R7
  abort_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(abort_wr) |-> pend == ($past(pend) && !$past(pend_clr)));

endmodule

// File: tb/sim_serial_shift_port.sv
module sim_serial_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       route_en = 1'b1, irq_en = 1'b0;
  logic       sh_wr = 1'b0, busy_wr = 1'b0, busy_wdata = 1'b0, pend_clr = 1'b0;
  logic [7:0] sh_wdata = 8'h00;
  logic       sin = 1'b0, gp_sck = 1'b0, gp_so = 1'b0;
  logic [7:0] shreg;
  logic       busy, pend, irq, pin_sck, pin_so;

  int checks = 0, errors = 0;
  logic [7:0] slave_byte = 8'h00;
  logic [7:0] cap = 8'h00;
  logic       prev_sck = 1'b0;
  int         rises = 0;

  always #10 clk = ~clk;

  serial_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .route_en(route_en),
    .irq_en(irq_en), .sh_wr(sh_wr), .sh_wdata(sh_wdata), .busy_wr(busy_wr),
    .busy_wdata(busy_wdata), .pend_clr(pend_clr), .sin(sin), .gp_sck(gp_sck),
    .gp_so(gp_so), .shreg(shreg), .busy(busy), .pend(pend), .irq(irq),
    .pin_sck(pin_sck), .pin_so(pin_so));

  always @(negedge clk) begin
    if (pin_sck && !prev_sck) begin
      rises = rises + 1;
      cap = {cap[6:0], pin_so};
    end else if (!busy) begin
      rises = 0;
    end
    prev_sck = pin_sck;
    sin = (rises < 8) ? slave_byte[7 - rises] : 1'b0;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 shreg write, 2 second start, 3 divide change, 4 abort
  task automatic xfer(input logic [1:0] d, input logic [7:0] tx, input logic [7:0] rx,
                      input int kind, output int cyc);
    div_sel = d; slave_byte = rx;
    @(negedge clk); sh_wr = 1'b1; sh_wdata = tx;
    @(negedge clk); sh_wr = 1'b0; busy_wr = 1'b1; busy_wdata = 1'b1;
    @(negedge clk); busy_wr = 1'b0;
    cyc = 0;
    while (busy && cyc < 400) begin
      cyc++;
      sh_wr = 1'b0; busy_wr = 1'b0;
      if (cyc == 5) begin
        case (kind)
          1: begin sh_wr = 1'b1; sh_wdata = ~tx; end
          2: begin busy_wr = 1'b1; busy_wdata = 1'b1; end
          3: div_sel = 2'b11;
          4: begin busy_wr = 1'b1; busy_wdata = 1'b0; end
          default: ;
        endcase
      end
      @(negedge clk);
    end
    sh_wr = 1'b0; busy_wr = 1'b0;
    @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {2'b00, 8'hA5, 8'h3C, 1'b1},
    {2'b01, 8'h81, 8'hFF, 1'b0},
    {2'b10, 8'h00, 8'h96, 1'b1},
    {2'b11, 8'h5A, 8'h01, 1'b1},
    {2'b00, 8'hFF, 8'h00, 1'b0},
    {2'b01, 8'h3E, 8'hC7, 1'b1}
  };

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !pend && !irq, "R1 flags", {busy, pend, irq}, 0);
    chk(!pin_sck && shreg == 8'h00, "R1 sck/shreg", {pin_sck, shreg}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] d;
      logic [7:0] tx, rx;
      int dv;
      {d, tx, rx, irq_en} = VEC[i];
      dv = (d == 2'b00) ? 2 : (d == 2'b01) ? 4 : 8;
      @(negedge clk); pend_clr = 1'b1;
      @(negedge clk); pend_clr = 1'b0;
      xfer(d, tx, rx, 0, cyc);
      chk(cyc == 15 * dv / 2, "R2 R3 busy length", cyc, 15 * dv / 2);
      chk(pend && !busy, "R5 pend set busy clear", {pend, busy}, 2);
      chk(shreg == rx, "R4 R5 received byte", shreg, rx);
      chk(cap == tx, "R4 sent msb first", cap, tx);
      chk(irq == irq_en, "R8 irq gating", irq, irq_en);
      chk(!pin_sck, "R10 sck idles low", pin_sck, 0);
    end

    // R8 pend clear
    irq_en = 1'b1;
    @(negedge clk); pend_clr = 1'b1;
    @(negedge clk); pend_clr = 1'b0;
    chk(!pend && !irq, "R8 pend clear", {pend, irq}, 0);

    // R6 write during transfer ignored
    xfer(2'b01, 8'hC3, 8'h5A, 1, cyc);
    chk(cap == 8'hC3, "R6 bits unchanged", cap, 8'hC3);
    chk(shreg == 8'h5A, "R6 received byte", shreg, 8'h5A);

    // R3 second start ignored
    xfer(2'b01, 8'h12, 8'h34, 2, cyc);
    chk(cyc == 30, "R3 restart ignored", cyc, 30);

    // R11 divide latched
    xfer(2'b00, 8'h77, 8'h88, 3, cyc);
    chk(cyc == 15, "R11 divide latched", cyc, 15);
    chk(shreg == 8'h88, "R11 data intact", shreg, 8'h88);

    // R7 abort
    div_sel = 2'b00;
    @(negedge clk); pend_clr = 1'b1;
    @(negedge clk); pend_clr = 1'b0;
    xfer(2'b11, 8'hF0, 8'h0F, 4, cyc);
    chk(cyc == 5, "R7 abort length", cyc, 5);
    chk(!pend && !busy, "R7 no pend on abort", {pend, busy}, 0);
    repeat (70) @(negedge clk);
    chk(!pend && !pin_sck, "R7 R10 stays idle", {pend, pin_sck}, 0);

    // R9 routing
    route_en = 1'b0; gp_sck = 1'b1; gp_so = 1'b0;
    @(negedge clk);
    chk(pin_sck == 1'b1 && pin_so == 1'b0, "R9 gp pins a", {pin_sck, pin_so}, 2);
    gp_sck = 1'b0; gp_so = 1'b1;
    @(negedge clk);
    chk(pin_sck == 1'b0 && pin_so == 1'b1, "R9 gp pins b", {pin_sck, pin_so}, 1);
    route_en = 1'b1;
    @(negedge clk);
    chk(pin_sck == 1'b0, "R9 routed idle sck", pin_sck, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule